// File: doc/BRIEF.md
# Flag Threshold Offset Programmer

This block keeps the two threshold offsets that a dual-clock FIFO's partial flag logic compares against: the empty offset (how close to empty the almost-empty flag switches) and the full offset (how close to full the almost-full flag switches). It decides how those offsets get their values and lets them be read back. Both offsets are presented continuously on `empty_ofs` and `full_ofs` for the flag comparators, which sit outside this block.

A single `load` input plays two parts. While master reset is sampled on the write clock, `load` selects the programming method and the default values. Afterwards it gates every offset access. In parallel mode, `load` with `wr_en` writes the low bits of `wr_data` into one offset per write-clock edge, alternating empty, full, empty and so on. In serial mode, `load` with `ser_en` shifts one bit of `ser_in` per write-clock edge into a chain of both offsets. On the read clock, `load` with `rd_en` places one offset per edge on `rd_data`, again alternating empty then full. Partial reset returns both alternation pointers to the empty offset and clears `rd_data`. It leaves the method and the offset values as they were.

Each alternation pointer is a two-state machine with the states EMPTY_SEL and FULL_SEL. The STEP transition (an access) moves EMPTY_SEL to FULL_SEL and FULL_SEL back to EMPTY_SEL. The CLEAR transition (master or partial reset) moves either state to EMPTY_SEL. Without an access or a reset the pointer holds.

Top module: `ofs_prog`

## Requirements
- R1: `mrst` high at a `wr_clk` edge with `load`=1 sets `serial_mode`=1 and both offsets to DFLT_SER (1023).
- R2: `mrst` high at a `wr_clk` edge with `load`=0 sets `serial_mode`=0 and both offsets to DFLT_PAR (127).
- R3: In parallel mode, each `wr_clk` edge with `load`=1 and `wr_en`=1 writes `wr_data[OW-1:0]` into the empty offset, then into the full offset on the next such edge, and so on alternately. Bits `wr_data[DW-1:OW]` are ignored.
- R4: Each `rd_clk` edge with `load`=1 and `rd_en`=1 loads `rd_data` with the empty offset, then the full offset on the next such edge, alternately. The offset is zero-extended into bits DW-1:OW. This read pointer moves independently of the write pointer.
- R5: Readback as in R4 works in serial mode as well.
- R6: In serial mode, each `wr_clk` edge with `load`=1 and `ser_en`=1 shifts `ser_in` into a 2*OW-bit chain. After 2*OW shifts, the first bit sent is empty offset bit 0 and the last bit sent is full offset bit OW-1.
- R7: The method changes only at master reset. In serial mode `load`/`wr_en` accesses change no offset, and in parallel mode `load`/`ser_en` accesses change no offset.
- R8: `prst` high at the clock edges keeps `serial_mode` and both offsets, returns both alternation pointers to the empty offset, and clears `rd_data` to zero.
- R9: With `load`=0, `wr_en`, `ser_en` and `rd_en` change neither the offsets nor `rd_data`.
- R10: `serial_mode` reports the method chosen at the last master reset (1 = serial, 0 = parallel).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| mrst | input | 1 | Master reset, synchronous, active high, sampled on both clocks |
| prst | input | 1 | Partial reset, synchronous, active high, sampled on both clocks |
| load | input | 1 | Method and default select at master reset; offset access gate otherwise |
| wr_en | input | 1 | Parallel offset write enable |
| ser_en | input | 1 | Serial offset shift enable |
| ser_in | input | 1 | Serial offset data bit |
| wr_data | input | DW | Parallel offset data |
| rd_en | input | 1 | Offset readback enable |
| rd_data | output | DW | Offset readback data, registered on rd_clk |
| serial_mode | output | 1 | 1 = serial method selected, 0 = parallel |
| empty_ofs | output | OW | Empty offset to the flag logic |
| full_ofs | output | OW | Full offset to the flag logic |

## Verification
The parallel path is driven with an interleaved table of writes and reads. The write and read pointers therefore sit on different registers at times, which exposes a shared or swapped pointer. The write data carries set upper bits, which exposes any failure to truncate or zero-extend. The serial path is given an asymmetric 26-bit pattern, so that a reversed shift direction or swapped halves yields visibly wrong offsets. Cross-method accesses, accesses without `load`, and partial reset taken with both pointers parked on the full register each separate "ignored" or "kept" from "acted upon".

// File: rtl/ofs_prog_pkg.sv
package ofs_prog_pkg;
    typedef enum logic {
        EMPTY_SEL = 1'b0,
        FULL_SEL  = 1'b1
    } ofs_sel_e;
endpackage

// File: rtl/ofs_alt_sel.sv
module ofs_alt_sel
    import ofs_prog_pkg::*;
(
    input  logic     clk,
    input  logic     clr,
    input  logic     step,
    output ofs_sel_e sel
);
    ofs_sel_e sel_nxt;

    // state register: CLEAR transition wins over STEP
    always_ff @(posedge clk) begin
        if (clr) sel <= EMPTY_SEL;
        else     sel <= sel_nxt;
    end

    // next-state: STEP toggles between the two registers
    always_comb begin
        sel_nxt = sel;
        unique case (sel)
            EMPTY_SEL: if (step) sel_nxt = FULL_SEL;
            FULL_SEL:  if (step) sel_nxt = EMPTY_SEL;
            default:   sel_nxt = EMPTY_SEL;
        endcase
    end
endmodule

// File: rtl/ofs_wr_side.sv
module ofs_wr_side
    import ofs_prog_pkg::*;
#(
    parameter int OW       = 13,
    parameter int DFLT_SER = 1023,
    parameter int DFLT_PAR = 127
) (
    input  logic          clk,
    input  logic          mrst,
    input  logic          prst,
    input  logic          load,
    input  logic          wr_en,
    input  logic          ser_en,
    input  logic          ser_in,
    input  logic [OW-1:0] wr_low,
    output logic          serial_mode,
    output logic [OW-1:0] empty_ofs,
    output logic [OW-1:0] full_ofs
);
    localparam logic [OW-1:0] DEF_S = OW'(DFLT_SER);
    localparam logic [OW-1:0] DEF_P = OW'(DFLT_PAR);

    ofs_sel_e wsel;
    logic     par_wr;
    logic     ser_sh;

    assign par_wr = !serial_mode && load && wr_en;
    assign ser_sh =  serial_mode && load && ser_en;

    ofs_alt_sel u_wsel (
        .clk  (clk),
        .clr  (mrst || prst),
        .step (par_wr),
        .sel  (wsel)
    );

    always_ff @(posedge clk) begin
        if (mrst) begin
            serial_mode <= load;
            empty_ofs   <= load ? DEF_S : DEF_P;
            full_ofs    <= load ? DEF_S : DEF_P;
        end else if (par_wr) begin
            if (wsel == EMPTY_SEL) empty_ofs <= wr_low;
            else                   full_ofs  <= wr_low;
        end else if (ser_sh) begin
            // chain {full, empty}, entering at the top, moving toward empty bit 0
            {full_ofs, empty_ofs} <= {ser_in, full_ofs, empty_ofs[OW-1:1]};
        end
    end
endmodule

// File: rtl/ofs_rd_side.sv
module ofs_rd_side
    import ofs_prog_pkg::*;
#(
    parameter int DW = 18,
    parameter int OW = 13
) (
    input  logic          clk,
    input  logic          mrst,
    input  logic          prst,
    input  logic          load,
    input  logic          rd_en,
    input  logic [OW-1:0] empty_ofs,
    input  logic [OW-1:0] full_ofs,
    output logic [DW-1:0] rd_data
);
    ofs_sel_e rsel;
    logic     rd_go;
    logic [OW-1:0] pick;

    assign rd_go = load && rd_en;
    assign pick  = (rsel == EMPTY_SEL) ? empty_ofs : full_ofs;

    ofs_alt_sel u_rsel (
        .clk  (clk),
        .clr  (mrst || prst),
        .step (rd_go),
        .sel  (rsel)
    );

    always_ff @(posedge clk) begin
        if (mrst || prst) rd_data <= '0;
        else if (rd_go)   rd_data <= {{(DW-OW){1'b0}}, pick};
    end
endmodule

// File: rtl/ofs_prog.sv
module ofs_prog #(
    parameter int DEPTH    = 8192,
    parameter int DW       = 18,
    parameter int DFLT_SER = 1023,
    parameter int DFLT_PAR = 127,
    localparam int OW      = $clog2(DEPTH)
) (
    input  logic          wr_clk,
    input  logic          rd_clk,
    input  logic          mrst,
    input  logic          prst,
    input  logic          load,
    input  logic          wr_en,
    input  logic          ser_en,
    input  logic          ser_in,
    input  logic [DW-1:0] wr_data,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          serial_mode,
    output logic [OW-1:0] empty_ofs,
    output logic [OW-1:0] full_ofs
);
    generate
        if (DW > OW) begin : g_hi
            logic unused_hi;
            assign unused_hi = ^wr_data[DW-1:OW];
        end
    endgenerate

    ofs_wr_side #(
        .OW       (OW),
        .DFLT_SER (DFLT_SER),
        .DFLT_PAR (DFLT_PAR)
    ) u_wr (
        .clk         (wr_clk),
        .mrst        (mrst),
        .prst        (prst),
        .load        (load),
        .wr_en       (wr_en),
        .ser_en      (ser_en),
        .ser_in      (ser_in),
        .wr_low      (wr_data[OW-1:0]),
        .serial_mode (serial_mode),
        .empty_ofs   (empty_ofs),
        .full_ofs    (full_ofs)
    );

    ofs_rd_side #(
        .DW (DW),
        .OW (OW)
    ) u_rd (
        .clk       (rd_clk),
        .mrst      (mrst),
        .prst      (prst),
        .load      (load),
        .rd_en     (rd_en),
        .empty_ofs (empty_ofs),
        .full_ofs  (full_ofs),
        .rd_data   (rd_data)
    );
endmodule

// File: rtl/ofs_prog_chk.sv
module ofs_prog_chk #(
    parameter int DW       = 18,
    parameter int OW       = 13,
    parameter int DFLT_SER = 1023,
    parameter int DFLT_PAR = 127
) (
    input logic          wr_clk,
    input logic          rd_clk,
    input logic          mrst,
    input logic          prst,
    input logic          load,
    input logic          wr_en,
    input logic          ser_en,
    input logic          rd_en,
    input logic [DW-1:0] rd_data,
    input logic          serial_mode,
    input logic [OW-1:0] empty_ofs,
    input logic [OW-1:0] full_ofs
);
    logic wseen = 1'b0;
    logic rseen = 1'b0;

    always_ff @(posedge wr_clk) if (mrst) wseen <= 1'b1;
    always_ff @(posedge rd_clk) if (mrst) rseen <= 1'b1;

    p_dflt_serial_r1: assert property (@(posedge wr_clk)
        (mrst && load) |=> (serial_mode && empty_ofs == OW'(DFLT_SER) && full_ofs == OW'(DFLT_SER)));

    p_dflt_parallel_r2: assert property (@(posedge wr_clk)
        (mrst && !load) |=> (!serial_mode && empty_ofs == OW'(DFLT_PAR) && full_ofs == OW'(DFLT_PAR)));

    // R10 / R7: method only moves at master reset
    p_mode_hold_r7: assert property (@(posedge wr_clk) disable iff (mrst)
        wseen |=> $stable(serial_mode));

    p_serial_no_par_r7: assert property (@(posedge wr_clk) disable iff (mrst)
        (wseen && serial_mode && !ser_en) |=> ($stable(empty_ofs) && $stable(full_ofs)));

    p_par_no_ser_r7: assert property (@(posedge wr_clk) disable iff (mrst)
        (wseen && !serial_mode && !wr_en) |=> ($stable(empty_ofs) && $stable(full_ofs)));

    p_no_load_wr_r9: assert property (@(posedge wr_clk) disable iff (mrst)
        (wseen && !load) |=> ($stable(empty_ofs) && $stable(full_ofs)));

    p_no_load_rd_r9: assert property (@(posedge rd_clk) disable iff (mrst || prst)
        (rseen && !(load && rd_en)) |=> $stable(rd_data));

    p_reset_clears_rd_r8: assert property (@(posedge rd_clk)
        (mrst || prst) |=> (rd_data == '0));
endmodule

bind ofs_prog ofs_prog_chk #(
    .DW       (DW),
    .OW       (OW),
    .DFLT_SER (DFLT_SER),
    .DFLT_PAR (DFLT_PAR)
) u_chk (
    .wr_clk      (wr_clk),
    .rd_clk      (rd_clk),
    .mrst        (mrst),
    .prst        (prst),
    .load        (load),
    .wr_en       (wr_en),
    .ser_en      (ser_en),
    .rd_en       (rd_en),
    .rd_data     (rd_data),
    .serial_mode (serial_mode),
    .empty_ofs   (empty_ofs),
    .full_ofs    (full_ofs)
);

// File: tb/ofs_prog_bench.sv
module ofs_prog_bench;
    localparam int DW = 18;
    localparam int OW = 13;

    logic          wr_clk = 1'b0;
    logic          rd_clk = 1'b0;
    logic          mrst   = 1'b1;
    logic          prst   = 1'b0;
    logic          load   = 1'b0;
    logic          wr_en  = 1'b0;
    logic          ser_en = 1'b0;
    logic          ser_in = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en  = 1'b0;
    logic [DW-1:0] rd_data;
    logic          serial_mode;
    logic [OW-1:0] empty_ofs;
    logic [OW-1:0] full_ofs;

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    always #2 wr_clk = ~wr_clk;
    always #2 rd_clk = ~rd_clk;

    ofs_prog u_ofs_prog (
        .wr_clk      (wr_clk),
        .rd_clk      (rd_clk),
        .mrst        (mrst),
        .prst        (prst),
        .load        (load),
        .wr_en       (wr_en),
        .ser_en      (ser_en),
        .ser_in      (ser_in),
        .wr_data     (wr_data),
        .rd_en       (rd_en),
        .rd_data     (rd_data),
        .serial_mode (serial_mode),
        .empty_ofs   (empty_ofs),
        .full_ofs    (full_ofs)
    );

    // vector: bit DW = 1 means read and compare, 0 means parallel write
    localparam logic [DW:0] VEC [8] = '{
        {1'b0, 18'h31234},   // write empty (upper bits dropped -> 0x1234)
        {1'b0, 18'h20055},   // write full -> 0x0055
        {1'b1, 18'h01234},   // read empty
        {1'b1, 18'h00055},   // read full
        {1'b1, 18'h01234},   // read empty again
        {1'b0, 18'h00ABC},   // write empty (write pointer back on empty)
        {1'b1, 18'h00055},   // read full (read pointer on full)
        {1'b1, 18'h00ABC}    // read empty
    };

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_mrst(input logic ld);
        @(negedge wr_clk); mrst = 1'b1; load = ld;
        @(negedge wr_clk); mrst = 1'b0; load = 1'b0;
        @(negedge wr_clk);
    endtask

    task automatic do_prst();
        @(negedge wr_clk); prst = 1'b1;
        @(negedge wr_clk); prst = 1'b0;
    endtask

    task automatic pwrite(input logic [DW-1:0] d);
        @(negedge wr_clk); load = 1'b1; wr_en = 1'b1; wr_data = d;
        @(negedge wr_clk); load = 1'b0; wr_en = 1'b0;
    endtask

    task automatic pread(output logic [DW-1:0] d);
        @(negedge rd_clk); load = 1'b1; rd_en = 1'b1;
        @(negedge rd_clk); d = rd_data; load = 1'b0; rd_en = 1'b0;
    endtask

    task automatic sshift(input logic b);
        @(negedge wr_clk); load = 1'b1; ser_en = 1'b1; ser_in = b;
        @(negedge wr_clk); load = 1'b0; ser_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #40000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [DW-1:0] got;
        logic [DW-1:0] keep;
        logic [2*OW-1:0] pat;

        // R2 / R10: parallel defaults
        do_mrst(1'b0);
        check("R10 mode after load=0", DW'(serial_mode), DW'(0));
        check("R2 empty default", DW'(empty_ofs), DW'(127));
        check("R2 full default", DW'(full_ofs), DW'(127));
        check("R8 rd_data cleared by reset", rd_data, '0);

        // R3 / R4: table of interleaved writes and reads
        foreach (VEC[i]) begin
            if (VEC[i][DW]) begin
                pread(got);
                check($sformatf("R4 vector %0d readback", i), got, VEC[i][DW-1:0]);
            end else begin
                pwrite(VEC[i][DW-1:0]);
            end
        end
        check("R3 empty after table", DW'(empty_ofs), DW'(13'h0ABC));
        check("R3 full after table", DW'(full_ofs), DW'(13'h0055));

        // R9: accesses without load
        @(negedge wr_clk); wr_en = 1'b1; ser_en = 1'b1; rd_en = 1'b1; wr_data = 18'h00777;
        @(negedge wr_clk); wr_en = 1'b0; ser_en = 1'b0; rd_en = 1'b0;
        check("R9 empty untouched without load", DW'(empty_ofs), DW'(13'h0ABC));
        check("R9 full untouched without load", DW'(full_ofs), DW'(13'h0055));
        check("R9 rd_data held without load", rd_data, 18'h00ABC);

        // R7: serial shifts ignored in parallel mode
        for (int i = 0; i < OW; i++) sshift(1'b1);
        check("R7 parallel mode ignores shift (empty)", DW'(empty_ofs), DW'(13'h0ABC));
        check("R7 parallel mode ignores shift (full)", DW'(full_ofs), DW'(13'h0055));

        // R8: partial reset; both pointers currently on full register
        do_prst();
        check("R8 empty kept", DW'(empty_ofs), DW'(13'h0ABC));
        check("R8 full kept", DW'(full_ofs), DW'(13'h0055));
        check("R8 mode kept", DW'(serial_mode), DW'(0));
        check("R8 rd_data cleared", rd_data, '0);
        pread(got);
        check("R8 read pointer back on empty", got, 18'h00ABC);
        pwrite(18'h00111);
        check("R8 write pointer back on empty", DW'(empty_ofs), DW'(13'h0111));
        check("R8 full not written", DW'(full_ofs), DW'(13'h0055));

        // R1 / R10: serial defaults
        do_mrst(1'b1);
        check("R10 mode after load=1", DW'(serial_mode), DW'(1));
        check("R1 empty default", DW'(empty_ofs), DW'(1023));
        check("R1 full default", DW'(full_ofs), DW'(1023));

        // R6: serial chain, first bit = empty bit 0, last = full MSB
        pat = {13'h1C3D, 13'h0A5B};
        for (int i = 0; i < 2*OW; i++) sshift(pat[i]);
        check("R6 serial empty", DW'(empty_ofs), DW'(13'h0A5B));
        check("R6 serial full", DW'(full_ofs), DW'(13'h1C3D));

        // R7: parallel write ignored in serial mode
        pwrite(18'h01FFF);
        check("R7 serial mode ignores write (empty)", DW'(empty_ofs), DW'(13'h0A5B));
        check("R7 serial mode ignores write (full)", DW'(full_ofs), DW'(13'h1C3D));

        // R5: readback in serial mode
        pread(got);
        check("R5 serial readback empty", got, 18'h00A5B);
        pread(got);
        check("R5 serial readback full", got, 18'h01C3D);
        keep = got;

        // R8 in serial mode
        do_prst();
        check("R8 serial mode kept", DW'(serial_mode), DW'(1));
        check("R8 serial empty kept", DW'(empty_ofs), DW'(13'h0A5B));
        check("R8 serial full kept", DW'(full_ofs), DW'(13'h1C3D));
        check("R8 rd_data cleared after readback", rd_data, (keep & '0));

        finish_run();
    end
endmodule